// File: doc/BRIEF.md
# Doorbell and Message Register Unit

This block gives a remote host and a local processor a small, register-based way to signal each other. Each side rings a 32-bit doorbell that the other side sees and clears bit by bit. Each side can also post 32-bit words into message slots that the other side collects. Two slots carry data toward the local side (inbound) and two carry data toward the host (outbound).

Each side has its own register port. A port takes a write strobe, a read strobe, a 4-bit offset and a write word. Read data comes back registered, one edge after the read. Both ports use the same offset layout, and each offset refers to the doorbell or slot from that side's point of view.

There are two interrupt outputs. The local interrupt is the OR of the unmasked pending inbound doorbell bits and the unmasked inbound message flags. The host interrupt is built the same way from the outbound sources. Each side masks only the sources it receives. Per-side offsets:

- 0: doorbell this side rings
- 1: doorbell this side receives
- 2: mask over the received doorbell
- 3: control
- 8+i: message slot i this side sends
- 12+i: message slot i this side receives

Top module: `db_msg_unit`

## Requirements
- R1: After reset every doorbell, mask, message word and flag is zero, both interrupts are low and both read-data outputs are zero.
- R2: A host write to offset 0 ORs the write word into the inbound doorbell. After that edge the local interrupt is high if any set bit is unmasked.
- R3: A local write to offset 1 clears each inbound doorbell bit whose write-word bit is 1. Bits written as 0 are unchanged, so a write of all zeros has no effect.
- R4: Outbound doorbell behaviour:
  - A local write to offset 0 ORs the write word into the outbound doorbell and asserts the host interrupt if any set bit is unmasked.
  - The outbound doorbell is cleared only by host writes of ones to offset 1.
  - The host interrupt falls only after a host access.
- R5: If a bit is set by one side and cleared by the other in the same cycle, it ends up set.
- R6: A write to offset 8+i (i = 0 or 1) stores the word in the sender's slot i and sets that slot's flag. The receiving side's interrupt rises after that edge unless the flag is masked.
- R7: A read of offset 12+i returns the word in slot i on read data after the read edge, and the same edge clears that slot's flag.
- R8: A write to offset 3 loads the receiver's message mask from bits [1:0] and clears the received flag i for each write-word bit 16+i that is 1. A read of offset 3 returns the mask in bits [1:0], the flags in bits [17:16], and zero elsewhere.
- R9: A 1 in the doorbell mask (offset 2) or in the message mask (offset 3, bit i) keeps that source off the interrupt. The source's state is still stored and can be read.
- R10: Read-back values:
  - Offset 0 returns the doorbell the side rings, offset 1 the doorbell it receives, offset 2 its doorbell mask, and offset 8+i the last word sent in slot i.
  - An unused offset reads zero.
  - Read data holds its value when no read occurs.
  - A read and a write in the same cycle return the state from before the write.
- R11: If a slot is written in the same cycle that the receiver reads or acknowledges it, the flag stays set and the new word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr_i | input | 1 | Host write strobe |
| h_rd_i | input | 1 | Host read strobe |
| h_addr_i | input | 4 | Host register offset |
| h_wdata_i | input | 32 | Host write word |
| h_rdata_o | output | 32 | Host read data, one edge after the read |
| l_wr_i | input | 1 | Local write strobe |
| l_rd_i | input | 1 | Local read strobe |
| l_addr_i | input | 4 | Local register offset |
| l_wdata_i | input | 32 | Local write word |
| l_rdata_o | output | 32 | Local read data, one edge after the read |
| irq_local_o | output | 1 | Interrupt toward the local processor |
| irq_host_o | output | 1 | Interrupt toward the remote host |

## Verification
Every write, read side effect and acknowledge takes effect on the edge where its strobe is sampled. Both interrupt lines are plain logic on stored state, so each one reflects that access as soon as the edge has passed. Read data is registered and shows the value from before the edge on which the read was sampled. The bench drives each access at a falling edge and lets one rising edge pass. At the next falling edge it compares both interrupts, and any read data, against a model updated from the pre-edge state.

// File: rtl/dbmu_pkg.sv
package dbmu_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam logic [ADDR_W-1:0] OFS_RING   = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_RXDB   = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_DBMASK = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'd3;
  localparam int unsigned OFS_TXMSG = 8;
  localparam int unsigned OFS_RXMSG = 12;
  localparam int unsigned ACK_LSB   = 16;
endpackage

// File: rtl/dbmu_doorbell.sv
module dbmu_doorbell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_d_i,
  output logic [DATA_W-1:0] bits_o,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] bits_q, mask_q;

  // set takes priority over a simultaneous clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      mask_q <= '0;
    end else begin
      bits_q <= (bits_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_d_i;
    end
  end

  assign bits_o = bits_q;
  assign mask_o = mask_q;

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((bits_o & $past(set_i)) == $past(set_i)));
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((bits_o & $past(clr_i & ~set_i)) == '0));
  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(bits_o));
endmodule

// File: rtl/dbmu_mailbox.sv
module dbmu_mailbox #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] data_q;
  logic              flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wdata_i;
      flag_q <= wr_i | (flag_q & ~clr_i);
    end
  end

  assign data_o = data_q;
  assign flag_o = flag_q;

  // R6
  post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (flag_o && data_o == $past(wdata_i)));
  // R7
  take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !wr_i) |=> !flag_o);
endmodule

// File: rtl/dbmu_port.sv
module dbmu_port
  import dbmu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MSG_N  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [DATA_W-1:0]       tx_db_i,
  input  logic [DATA_W-1:0]       rx_db_i,
  input  logic [DATA_W-1:0]       rx_db_mask_i,
  input  logic [MSG_N*DATA_W-1:0] tx_msg_i,
  input  logic [MSG_N*DATA_W-1:0] rx_msg_i,
  input  logic [MSG_N-1:0]        rx_flag_i,
  output logic [DATA_W-1:0]       tx_db_set_o,
  output logic [DATA_W-1:0]       rx_db_clr_o,
  output logic                    rx_db_mask_we_o,
  output logic [MSG_N-1:0]        tx_msg_we_o,
  output logic [MSG_N-1:0]        rx_msg_clr_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    irq_o
);
  logic              ctrl_we;
  logic [MSG_N-1:0]  mmask_q;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    tx_db_set_o     = (wr_i && addr_i == OFS_RING) ? wdata_i : '0;
    rx_db_clr_o     = (wr_i && addr_i == OFS_RXDB) ? wdata_i : '0;
    rx_db_mask_we_o = wr_i && addr_i == OFS_DBMASK;
    ctrl_we         = wr_i && addr_i == OFS_CTRL;
  end

  for (genvar i = 0; i < MSG_N; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] TX_A = ADDR_W'(OFS_TXMSG + i);
    localparam logic [ADDR_W-1:0] RX_A = ADDR_W'(OFS_RXMSG + i);
    assign tx_msg_we_o[i]  = wr_i && addr_i == TX_A;
    assign rx_msg_clr_o[i] = (rd_i && addr_i == RX_A) || (ctrl_we && wdata_i[ACK_LSB+i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mmask_q <= '0;
    else if (ctrl_we) mmask_q <= wdata_i[MSG_N-1:0];
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFS_RING:   rd_val = tx_db_i;
      OFS_RXDB:   rd_val = rx_db_i;
      OFS_DBMASK: rd_val = rx_db_mask_i;
      OFS_CTRL: begin
        rd_val[MSG_N-1:0]       = mmask_q;
        rd_val[ACK_LSB+:MSG_N]  = rx_flag_i;
      end
      default: ;
    endcase
    for (int i = 0; i < MSG_N; i++) begin
      if (addr_i == ADDR_W'(OFS_TXMSG + i)) rd_val = tx_msg_i[i*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(OFS_RXMSG + i)) rd_val = rx_msg_i[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = (|(rx_db_i & ~rx_db_mask_i)) | (|(rx_flag_i & ~mmask_q));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/db_msg_unit.sv
module db_msg_unit
  import dbmu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MSG_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr_i,
  input  logic              h_rd_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  output logic [DATA_W-1:0] h_rdata_o,
  input  logic              l_wr_i,
  input  logic              l_rd_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              irq_local_o,
  output logic              irq_host_o
);
  localparam int unsigned MW = MSG_N * DATA_W;

  logic [DATA_W-1:0] ib_bits, ib_mask, ob_bits, ob_mask;
  logic [DATA_W-1:0] h_ring_set, h_rx_clr, l_ring_set, l_rx_clr;
  logic              h_mask_we, l_mask_we;
  logic [MSG_N-1:0]  h_tx_we, h_rx_take, l_tx_we, l_rx_take;
  logic [MW-1:0]     imsg, omsg;
  logic [MSG_N-1:0]  iflag, oflag;

  dbmu_port #(.DATA_W(DATA_W), .MSG_N(MSG_N)) u_hport (
    .clk(clk), .rst_n(rst_n), .wr_i(h_wr_i), .rd_i(h_rd_i), .addr_i(h_addr_i),
    .wdata_i(h_wdata_i), .tx_db_i(ib_bits), .rx_db_i(ob_bits), .rx_db_mask_i(ob_mask),
    .tx_msg_i(imsg), .rx_msg_i(omsg), .rx_flag_i(oflag),
    .tx_db_set_o(h_ring_set), .rx_db_clr_o(h_rx_clr), .rx_db_mask_we_o(h_mask_we),
    .tx_msg_we_o(h_tx_we), .rx_msg_clr_o(h_rx_take), .rdata_o(h_rdata_o), .irq_o(irq_host_o)
  );

  dbmu_port #(.DATA_W(DATA_W), .MSG_N(MSG_N)) u_lport (
    .clk(clk), .rst_n(rst_n), .wr_i(l_wr_i), .rd_i(l_rd_i), .addr_i(l_addr_i),
    .wdata_i(l_wdata_i), .tx_db_i(ob_bits), .rx_db_i(ib_bits), .rx_db_mask_i(ib_mask),
    .tx_msg_i(omsg), .rx_msg_i(imsg), .rx_flag_i(iflag),
    .tx_db_set_o(l_ring_set), .rx_db_clr_o(l_rx_clr), .rx_db_mask_we_o(l_mask_we),
    .tx_msg_we_o(l_tx_we), .rx_msg_clr_o(l_rx_take), .rdata_o(l_rdata_o), .irq_o(irq_local_o)
  );

  dbmu_doorbell #(.DATA_W(DATA_W)) u_ib (
    .clk(clk), .rst_n(rst_n), .set_i(h_ring_set), .clr_i(l_rx_clr),
    .mask_we_i(l_mask_we), .mask_d_i(l_wdata_i), .bits_o(ib_bits), .mask_o(ib_mask)
  );

  dbmu_doorbell #(.DATA_W(DATA_W)) u_ob (
    .clk(clk), .rst_n(rst_n), .set_i(l_ring_set), .clr_i(h_rx_clr),
    .mask_we_i(h_mask_we), .mask_d_i(h_wdata_i), .bits_o(ob_bits), .mask_o(ob_mask)
  );

  for (genvar i = 0; i < MSG_N; i++) begin : g_mbox
    dbmu_mailbox #(.DATA_W(DATA_W)) u_in (
      .clk(clk), .rst_n(rst_n), .wr_i(h_tx_we[i]), .wdata_i(h_wdata_i),
      .clr_i(l_rx_take[i]), .data_o(imsg[i*DATA_W +: DATA_W]), .flag_o(iflag[i])
    );
    dbmu_mailbox #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .wr_i(l_tx_we[i]), .wdata_i(l_wdata_i),
      .clr_i(h_rx_take[i]), .data_o(omsg[i*DATA_W +: DATA_W]), .flag_o(oflag[i])
    );
  end

  // R4
  host_irq_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_host_o) |-> $past(h_wr_i || h_rd_i));
  // R3
  local_irq_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_local_o) |-> $past(l_wr_i || l_rd_i));
endmodule

// File: tb/tb_db_msg_unit.sv
module tb_db_msg_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [3:0] h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic irq_local, irq_host;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  db_msg_unit dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr_i(h_wr), .h_rd_i(h_rd), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .l_wr_i(l_wr), .l_rd_i(l_rd), .l_addr_i(l_addr), .l_wdata_i(l_wdata), .l_rdata_o(l_rdata),
    .irq_local_o(irq_local), .irq_host_o(irq_host)
  );

  // model state
  logic [31:0] m_ib = 0, m_ob = 0, m_ibm = 0, m_obm = 0;
  logic [31:0] m_imsg [2];
  logic [31:0] m_omsg [2];
  logic [1:0]  m_if = 0, m_of = 0, m_lmm = 0, m_hmm = 0;

  function automatic logic [31:0] exp_rd(bit host, logic [3:0] a);
    logic [31:0] v = 0;
    case (a)
      4'd0: v = host ? m_ib : m_ob;
      4'd1: v = host ? m_ob : m_ib;
      4'd2: v = host ? m_obm : m_ibm;
      4'd3: v = host ? {14'd0, m_of, 14'd0, m_hmm} : {14'd0, m_if, 14'd0, m_lmm};
      4'd8, 4'd9:   v = host ? m_imsg[a[0]] : m_omsg[a[0]];
      4'd12, 4'd13: v = host ? m_omsg[a[0]] : m_imsg[a[0]];
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit exp_irq_local();
    return (|(m_ib & ~m_ibm)) || (|(m_if & ~m_lmm));
  endfunction
  function automatic bit exp_irq_host();
    return (|(m_ob & ~m_obm)) || (|(m_of & ~m_hmm));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic update_model(bit hw, logic [3:0] ha, logic [31:0] hd, bit hr, logic [3:0] hra,
                              bit lw, logic [3:0] la, logic [31:0] ld, bit lr, logic [3:0] lra);
    logic [31:0] nib, nob;
    nib = (m_ib & ~((lw && la == 1) ? ld : 32'd0)) | ((hw && ha == 0) ? hd : 32'd0);
    nob = (m_ob & ~((hw && ha == 1) ? hd : 32'd0)) | ((lw && la == 0) ? ld : 32'd0);
    m_ib = nib; m_ob = nob;
    if (lw && la == 2) m_ibm = ld;
    if (hw && ha == 2) m_obm = hd;
    for (int i = 0; i < 2; i++) begin
      bit iclr, oclr, iset, oset;
      iclr = (lr && lra == 4'(12 + i)) || (lw && la == 3 && ld[16+i]);
      oclr = (hr && hra == 4'(12 + i)) || (hw && ha == 3 && hd[16+i]);
      iset = hw && ha == 4'(8 + i);
      oset = lw && la == 4'(8 + i);
      if (iset) m_imsg[i] = hd;
      if (oset) m_omsg[i] = ld;
      m_if[i] = iset | (m_if[i] & ~iclr);
      m_of[i] = oset | (m_of[i] & ~oclr);
    end
    if (lw && la == 3) m_lmm = ld[1:0];
    if (hw && ha == 3) m_hmm = hd[1:0];
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(string tag,
                      bit hw, logic [3:0] ha, logic [31:0] hd, bit hr, logic [3:0] hra,
                      bit lw, logic [3:0] la, logic [31:0] ld, bit lr, logic [3:0] lra);
    logic [31:0] eh, el;
    h_wr = hw; h_rd = hr; h_wdata = hd; h_addr = hw ? ha : hra;
    l_wr = lw; l_rd = lr; l_wdata = ld; l_addr = lw ? la : lra;
    // one address per side: a read in the same call uses the write address
    if (hw && hr) hra = ha;
    if (lw && lr) lra = la;
    eh = exp_rd(1'b1, hra);
    el = exp_rd(1'b0, lra);
    @(posedge clk);
    update_model(hw, ha, hd, hr, hra, lw, la, ld, lr, lra);
    @(negedge clk);
    h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
    chk({tag, " irq_local"}, 32'(irq_local), 32'(exp_irq_local()));
    chk({tag, " irq_host"}, 32'(irq_host), 32'(exp_irq_host()));
    if (hr) chk({tag, " host rdata"}, h_rdata, eh);
    if (lr) chk({tag, " local rdata"}, l_rdata, el);
  endtask

  function automatic logic [3:0] pick_addr();
    logic [3:0] tbl [10] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd12, 4'd13, 4'd5, 4'd15};
    return tbl[$urandom % 10];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    m_imsg[0] = 0; m_imsg[1] = 0; m_omsg[0] = 0; m_omsg[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq_local", 32'(irq_local), 0);
    chk("R1 irq_host", 32'(irq_host), 0);
    chk("R1 h_rdata", h_rdata, 0);
    chk("R1 l_rdata", l_rdata, 0);
    step("R1", 0,0,0, 1,4'd3, 0,0,0, 1,4'd12);
    // R2 host rings inbound doorbell
    step("R2", 1,4'd0,32'hA5A5_0001, 0,0, 0,0,0, 0,0);
    step("R10", 0,0,0, 1,4'd0, 0,0,0, 1,4'd1);
    // R3 zero write ignored, partial and full clear
    step("R3", 0,0,0, 0,0, 1,4'd1,32'h0, 0,0);
    step("R3", 0,0,0, 0,0, 0,0,0, 1,4'd1);
    step("R3", 0,0,0, 0,0, 1,4'd1,32'h0000_0001, 0,0);
    step("R3", 0,0,0, 0,0, 0,0,0, 1,4'd1);
    step("R3", 0,0,0, 0,0, 1,4'd1,32'hFFFF_FFFF, 0,0);
    // R4 outbound doorbell
    step("R4", 0,0,0, 0,0, 1,4'd0,32'h0000_0080, 0,0);
    step("R4", 1,4'd1,32'h0, 0,0, 0,0,0, 0,0);
    step("R4", 1,4'd1,32'h0000_0080, 0,0, 0,0,0, 0,0);
    // R5 set and clear of the same bit together
    step("R5", 1,4'd0,32'h10, 0,0, 1,4'd1,32'h10, 0,0);
    step("R5", 0,0,0, 0,0, 0,0,0, 1,4'd1);
    step("R5", 0,0,0, 0,0, 1,4'd1,32'h10, 0,0);
    // R6 / R7 inbound message
    step("R6", 1,4'd8,32'hDEAD_BEEF, 0,0, 0,0,0, 0,0);
    step("R7", 0,0,0, 0,0, 0,0,0, 1,4'd12);
    // R8 outbound message acknowledged through control
    step("R6", 0,0,0, 0,0, 1,4'd9,32'h1234_5678, 0,0);
    step("R8", 0,0,0, 1,4'd3, 0,0,0, 0,0);
    step("R8", 1,4'd3,32'h0002_0000, 0,0, 0,0,0, 0,0);
    step("R8", 0,0,0, 1,4'd13, 0,0,0, 0,0);
    // R9 masking
    step("R9", 0,0,0, 0,0, 1,4'd2,32'hFFFF_FFFF, 0,0);
    step("R9", 1,4'd0,32'h0000_0300, 0,0, 0,0,0, 0,0);
    step("R9", 0,0,0, 0,0, 0,0,0, 1,4'd1);
    step("R9", 0,0,0, 0,0, 1,4'd3,32'h0000_0003, 0,0);
    step("R9", 1,4'd9,32'h0BAD_F00D, 0,0, 0,0,0, 0,0);
    step("R9", 0,0,0, 0,0, 1,4'd2,32'h0, 0,0);
    step("R9", 0,0,0, 0,0, 1,4'd3,32'h0, 0,0);
    step("R9", 0,0,0, 0,0, 1,4'd1,32'hFFFF_FFFF, 1,4'd1);
    // R11 write and read of a slot in the same cycle
    step("R11", 1,4'd9,32'h5555_AAAA, 0,0, 0,0,0, 1,4'd13);
    step("R11", 0,0,0, 0,0, 0,0,0, 1,4'd3);
    step("R10", 0,0,0, 1,4'd5, 0,0,0, 1,4'd15);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit hw, hr, lw, lr;
      logic [3:0] ha, la;
      logic [31:0] hd, ld;
      hw = ($urandom % 2) == 0; hr = ($urandom % 3) == 0;
      lw = ($urandom % 2) == 0; lr = ($urandom % 3) == 0;
      ha = pick_addr(); la = pick_addr();
      hd = $urandom; ld = $urandom;
      if (ha == 4'd2) hd = hd & $urandom & $urandom;
      if (la == 4'd2) ld = ld & $urandom & $urandom;
      step("R9", hw, ha, hd, hr, ha, lw, la, ld, lr, la);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule